// File: doc/BRIEF.md
# Up/Down Timer with Buffered Compare Channel

This block is an 8-bit timer/counter that can count in both directions. It has one output compare channel, and the compare value can be buffered. The counter moves one step on every clock cycle in which the single-cycle `tick` enable is high. A clock-enable source outside the block supplies that pulse. Four modes set the count sequence and the TOP value:

- a free-running up count;
- clear-on-match, where TOP is the compare value;
- single-slope PWM;
- dual-slope PWM.

The block sets an overflow flag and a match flag. Each flag is gated by its own mask bit into an interrupt line. The block also drives one waveform pin for PWM or frequency output.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. The address map is:

| Address | Register | Contents |
|---|---|---|
| 0 | mode | bits [1:0] |
| 1 | counter | count value |
| 2 | compare | buffered compare value |
| 3 | flags | bit 0 = overflow, bit 1 = match |
| 4 | mask | same bit layout as the flags |

Mode codes are 00 free-run, 01 clear-on-match, 10 single-slope PWM and 11 dual-slope PWM.

Top module: `updn_tmr`

## Requirements
- R1: After reset the counter, the direction (up), the mode (00), the compare values, the flags, the masks and `wave_out` are all zero, and both interrupt lines are low.
- R2: In mode 00 each tick adds one to the counter, and a tick at 0xFF gives 0x00.
- R3: In mode 01, a tick taken while the counter equals the active compare value loads 0x00 into the counter.
- R4: In modes 10 and 11, a compare write goes only to the buffer, and reading address 2 returns the buffer. The active value is copied from the buffer on a tick at 0xFF in mode 10, or on a tick at 0x00 in mode 11. In modes 00 and 01 a compare write takes effect at once.
- R5: In modes 00, 01 and 10 the overflow flag (bit 0) is set by a tick at 0xFF. In mode 11 it is set only by a tick at 0x00 while counting down.
- R6: In mode 11 the counter counts up to 0xFF, turns, and counts down to 0x00. A tick at 0xFF while counting up gives 0xFE. Writing the mode register sets the direction to up.
- R7: `irq_ovf` is high exactly when flag bit 0 and mask bit 0 are both set, and `irq_cmp` likewise for bit 1.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R9: A tick taken while the counter equals the active compare value sets the match flag (bit 1). In mode 01 it also toggles `wave_out`.
- R10: After a write to the counter, the next tick raises no match flag and causes no compare-driven waveform change.
- R11: In mode 10, `wave_out` is set by a tick at 0xFF and cleared by a match. If both happen on the same tick, the set wins.
- R12: In mode 11, a match while counting up clears `wave_out`, and a match while counting down sets it.
- R13: In any cycle with no tick and no counter or mode write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational from `addr` |
| irq_ovf | output | 1 | Masked overflow interrupt |
| irq_cmp | output | 1 | Masked match interrupt |
| wave_out | output | 1 | Compare waveform output |

## Verification
The bench builds the block with W = 8 and DBUF = 1. With an 8-bit counter, the wrap at 0xFF and both turning points of the dual-slope mode are only a handful of ticks away once the counter is preloaded. With buffering enabled, the deferred copy of the compare value at TOP and at BOTTOM can be observed. The bench watches the match flag and the waveform pin to tell the old compare value from the new one around those load points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      M_FREE  = 2'b00,
      M_CLRM  = 2'b01,
      M_FAST  = 2'b10,
      M_DUAL  = 2'b11
   } tmr_mode_e;

   localparam int unsigned AW = 3;
   localparam logic [AW-1:0] A_MODE = 3'd0;
   localparam logic [AW-1:0] A_CNT  = 3'd1;
   localparam logic [AW-1:0] A_CMP  = 3'd2;
   localparam logic [AW-1:0] A_FLG  = 3'd3;
   localparam logic [AW-1:0] A_MSK  = 3'd4;
endpackage

// File: rtl/tmr_count.sv
module tmr_count
   import tmr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  tmr_mode_e    mode,
   input  logic [W-1:0] cmp_act,
   input  logic         ld_en,
   input  logic [W-1:0] ld_val,
   input  logic         mode_wr,
   output logic [W-1:0] cnt,
   output logic         dir_dn,
   output logic         ovf_evt
);
   localparam logic [W-1:0] MAXV = '1;
   localparam logic [W-1:0] ONE  = W'(1);

   logic [W-1:0] top_val;

   always_comb begin
      top_val = (mode == M_CLRM) ? cmp_act : MAXV;
      if (mode == M_DUAL)
         ovf_evt = step && dir_dn && (cnt == '0);
      else
         ovf_evt = step && (cnt == MAXV);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_dn <= 1'b0;
      end else begin
         if (mode_wr) dir_dn <= 1'b0;
         if (ld_en) cnt <= ld_val;
         if (step) begin
            if (mode == M_DUAL) begin
               if (!dir_dn) begin
                  if (cnt == MAXV) begin
                     dir_dn <= 1'b1;
                     cnt    <= cnt - ONE;
                  end else begin
                     cnt <= cnt + ONE;
                  end
               end else begin
                  if (cnt == '0) begin
                     dir_dn <= 1'b0;
                     cnt    <= cnt + ONE;
                  end else begin
                     cnt <= cnt - ONE;
                  end
               end
            end else begin
               cnt <= (cnt == top_val) ? '0 : cnt + ONE;
            end
         end
      end
   end
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp
   import tmr_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter bit          DBUF = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  tmr_mode_e    mode,
   input  logic [W-1:0] cnt,
   input  logic         cmp_wr,
   input  logic         cnt_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cmp_buf,
   output logic [W-1:0] cmp_act,
   output logic         match
);
   localparam logic [W-1:0] MAXV = '1;

   logic blk_q;

   generate
      if (DBUF) begin : g_buf
         logic [W-1:0] buf_q;
         logic         pwm;
         logic         load_pt;
         assign pwm     = mode[1];
         assign load_pt = step && (((mode == M_FAST) && (cnt == MAXV)) ||
                                   ((mode == M_DUAL) && (cnt == '0)));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               buf_q   <= '0;
               cmp_act <= '0;
            end else begin
               if (cmp_wr) buf_q <= wdata;
               if (cmp_wr && !pwm)
                  cmp_act <= wdata;
               else if (pwm && load_pt)
                  cmp_act <= buf_q;
            end
         end
         assign cmp_buf = buf_q;
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) cmp_act <= '0;
            else if (cmp_wr) cmp_act <= wdata;
         end
         assign cmp_buf = cmp_act;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      blk_q <= 1'b0;
      else if (cnt_wr) blk_q <= 1'b1;
      else if (step)   blk_q <= 1'b0;
   end

   assign match = step && !blk_q && (cnt == cmp_act);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
   import tmr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  tmr_mode_e    mode,
   input  logic [W-1:0] cnt,
   input  logic         dir_dn,
   input  logic         match,
   output logic         wave
);
   localparam logic [W-1:0] MAXV = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wave <= 1'b0;
      end else begin
         unique case (mode)
            M_CLRM: if (match) wave <= ~wave;
            M_FAST: begin
               if (step && (cnt == MAXV)) wave <= 1'b1;
               else if (match)            wave <= 1'b0;
            end
            M_DUAL: if (match) wave <= dir_dn;
            default: wave <= wave;
         endcase
      end
   end
endmodule

// File: rtl/updn_tmr.sv
module updn_tmr
   import tmr_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter bit          DBUF = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata,
   output logic          irq_ovf,
   output logic          irq_cmp,
   output logic          wave_out
);
   generate
      if (W < 2) begin : g_bad_w
         $error("updn_tmr: W must be at least 2");
      end
   endgenerate

   tmr_mode_e    mode_q;
   logic [1:0]   flg_q;
   logic [1:0]   msk_q;
   logic [W-1:0] cnt_q;
   logic         dir_q;
   logic [W-1:0] cmp_buf;
   logic [W-1:0] cmp_act;
   logic         ovf_evt;
   logic         match;
   logic         wr_mode, wr_cnt, wr_cmp, wr_flg, wr_msk;
   logic         step;

   assign wr_mode = wr_en && (addr == A_MODE);
   assign wr_cnt  = wr_en && (addr == A_CNT);
   assign wr_cmp  = wr_en && (addr == A_CMP);
   assign wr_flg  = wr_en && (addr == A_FLG);
   assign wr_msk  = wr_en && (addr == A_MSK);
   assign step    = tick && !wr_cnt && !wr_mode;

   tmr_count #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .mode(mode_q),
      .cmp_act(cmp_act), .ld_en(wr_cnt), .ld_val(wdata),
      .mode_wr(wr_mode), .cnt(cnt_q), .dir_dn(dir_q), .ovf_evt(ovf_evt)
   );

   tmr_cmp #(.W(W), .DBUF(DBUF)) u_cmp (
      .clk(clk), .rst_n(rst_n), .step(step), .mode(mode_q), .cnt(cnt_q),
      .cmp_wr(wr_cmp), .cnt_wr(wr_cnt), .wdata(wdata),
      .cmp_buf(cmp_buf), .cmp_act(cmp_act), .match(match)
   );

   tmr_wave #(.W(W)) u_wave (
      .clk(clk), .rst_n(rst_n), .step(step), .mode(mode_q), .cnt(cnt_q),
      .dir_dn(dir_q), .match(match), .wave(wave_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= M_FREE;
         flg_q  <= '0;
         msk_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= tmr_mode_e'(wdata[1:0]);
         if (wr_msk)  msk_q  <= wdata[1:0];
         flg_q[0] <= ovf_evt | (flg_q[0] & ~(wr_flg & wdata[0]));
         flg_q[1] <= match   | (flg_q[1] & ~(wr_flg & wdata[1]));
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_MODE:  rdata[1:0] = mode_q;
         A_CNT:   rdata      = cnt_q;
         A_CMP:   rdata      = cmp_buf;
         A_FLG:   rdata[1:0] = flg_q;
         A_MSK:   rdata[1:0] = msk_q;
         default: rdata      = '0;
      endcase
   end

   assign irq_ovf = flg_q[0] & msk_q[0];
   assign irq_cmp = flg_q[1] & msk_q[1];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
   import tmr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          wr_en,
   input logic [AW-1:0] addr,
   input logic [W-1:0]  cnt,
   input logic          dir_dn,
   input logic [1:0]    mode,
   input logic [W-1:0]  cmp_act,
   input logic          ovf_f,
   input logic          cmp_f
);
   localparam logic [W-1:0] MAXV = '1;

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && mode == 2'b00 && cnt == MAXV) |=> (cnt == '0));

   p_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && mode == 2'b11 && !dir_dn && cnt == MAXV)
      |=> (cnt == MAXV - W'(1) && dir_dn));

   p_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && mode != 2'b11 && cnt == MAXV) |=> ovf_f);

   p_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMP && mode == 2'b10 && !(tick && cnt == MAXV))
      |=> $stable(cmp_act));

   p_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_f) |-> $past(tick));

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(cnt));
endmodule

bind updn_tmr tmr_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
   .cnt(cnt_q), .dir_dn(dir_q), .mode(mode_q), .cmp_act(cmp_act),
   .ovf_f(flg_q[0]), .cmp_f(flg_q[1])
);

// File: tb/sim_updn_tmr.sv
module sim_updn_tmr;
   localparam int PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   addr = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq_ovf, irq_cmp, wave_out;
   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   updn_tmr #(.W(W), .DBUF(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp),
      .wave_out(wave_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      rd(3'd1, v); chk("R1 count", v, 0);
      rd(3'd0, v); chk("R1 mode", v, 0);
      rd(3'd3, v); chk("R1 flags", v, 0);
      rd(3'd2, v); chk("R1 compare", v, 0);
      chk("R1 wave", int'(wave_out), 0);
      chk("R1 irq", int'({irq_ovf, irq_cmp}), 0);
   endtask

   task automatic t_free();
      int v;
      wr(3'd1, 8'hFD);
      tk(3);
      rd(3'd1, v); chk("R2 wrap", v, 0);
      rd(3'd3, v); chk("R5 ovf at max", v, 1);
      chk("R7 masked off", int'(irq_ovf), 0);
      wr(3'd4, 8'h01);
      chk("R7 ovf irq", int'(irq_ovf), 1);
      wr(3'd3, 8'h00);
      rd(3'd3, v); chk("R8 zero write", v, 1);
      wr(3'd3, 8'h01);
      rd(3'd3, v); chk("R8 clear", v, 0);
      chk("R7 irq low", int'(irq_ovf), 0);
   endtask

   task automatic t_clrm();
      int v;
      wr(3'd0, 8'h01);
      wr(3'd2, 8'h03);
      wr(3'd1, 8'h00);
      tk(4);
      rd(3'd1, v); chk("R3 cleared at match", v, 0);
      rd(3'd3, v); chk("R9 match flag", v, 2);
      chk("R9 toggle high", int'(wave_out), 1);
      tk(4);
      chk("R9 toggle low", int'(wave_out), 0);
      wr(3'd3, 8'h03);
   endtask

   task automatic t_block();
      int v;
      wr(3'd2, 8'h05);
      wr(3'd1, 8'h05);
      tk(1);
      rd(3'd1, v); chk("R3 top clear", v, 0);
      rd(3'd3, v); chk("R10 match blocked", v, 0);
      chk("R10 wave held", int'(wave_out), 0);
      tk(5);
      rd(3'd3, v); chk("R10 before match", v, 0);
      tk(1);
      rd(3'd3, v); chk("R9 match after block", v, 2);
      chk("R9 toggle", int'(wave_out), 1);
      wr(3'd3, 8'h03);
   endtask

   task automatic t_fast();
      int v;
      wr(3'd0, 8'h02);
      wr(3'd2, 8'h20);
      rd(3'd2, v); chk("R4 reads buffer", v, 8'h20);
      wr(3'd1, 8'h10);
      tk(17);
      rd(3'd1, v); chk("R2 count", v, 8'h21);
      rd(3'd3, v); chk("R4 buffer not active", v, 0);
      wr(3'd1, 8'hFE);
      tk(2);
      rd(3'd1, v); chk("R11 wrap", v, 0);
      rd(3'd3, v); chk("R5 fast ovf", v, 1);
      wr(3'd3, 8'h03);
      tk(8'h20);
      chk("R11 high before match", int'(wave_out), 1);
      tk(1);
      chk("R11 cleared on match", int'(wave_out), 0);
      rd(3'd3, v); chk("R4 new value active", v, 2);
      wr(3'd3, 8'h03);
      wr(3'd1, 8'hFF);
      tk(1);
      chk("R11 set at max", int'(wave_out), 1);
      wr(3'd3, 8'h03);
   endtask

   task automatic t_dual();
      int v;
      wr(3'd0, 8'h03);
      wr(3'd2, 8'h40);
      wr(3'd1, 8'hFD);
      tk(3);
      rd(3'd1, v); chk("R6 turn at max", v, 8'hFE);
      rd(3'd3, v); chk("R5 no ovf at max in dual", v, 0);
      wr(3'd1, 8'h02);
      tk(3);
      rd(3'd1, v); chk("R6 turn at bottom", v, 1);
      rd(3'd3, v); chk("R5 ovf at bottom", v, 1);
      wr(3'd3, 8'h03);
      wr(3'd1, 8'h3F);
      tk(2);
      chk("R12 clear on up match", int'(wave_out), 0);
      rd(3'd3, v); chk("R4 loaded at bottom", v, 2);
      wr(3'd1, 8'hFF);
      tk(1);
      wr(3'd1, 8'h41);
      tk(2);
      chk("R12 set on down match", int'(wave_out), 1);
      rd(3'd1, v); chk("R6 counting down", v, 8'h3F);
   endtask

   task automatic t_irq_hold();
      int v;
      wr(3'd4, 8'h02);
      chk("R7 cmp irq", int'({irq_ovf, irq_cmp}), 1);
      wr(3'd3, 8'h02);
      chk("R8 cmp cleared", int'(irq_cmp), 0);
      rd(3'd1, v);
      repeat (10) @(negedge clk);
      rd(3'd1, v); chk("R13 hold", v, 8'h3F);
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_free();
      t_clrm();
      t_block();
      t_fast();
      t_dual();
      t_irq_hold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule